// File: doc/BRIEF.md
# Graded Low-Power Mode Sequencer

This block decides which clocks of a small processor subsystem run. It drives registered clock enables for a set of execution units, for the bus interface and for the clock generator. It also drives a keep-alive output for the PLL. Software asks for one of four graded modes through a request strobe. Each deeper mode stops every clock the shallower one stopped, plus one more. Full-on runs everything. Doze stops the execution units. Nap also stops the bus. Sleep also stops the clock generator and, if the keep bit is clear, powers the PLL down.

Moves between modes go one level per clock cycle, and the sequencer reports a busy flag while a move is under way. A small wake detector keeps running in every mode. An external wake event brings the subsystem back to full-on, and the clocks come back in reverse order: generator, then bus, then execution units. If the PLL was powered down, a programmable lock wait is inserted after the generator comes back and before the bus clock returns. While the subsystem is fully on, an execution unit that reports itself idle has its own enable dropped one cycle later.

Named states of the sequencer: `ST_IDLE` (stable, accepts requests and wakes), `ST_DOWN` (stepping deeper), `ST_UP` (stepping shallower) and `ST_LOCK` (lock wait after the generator returns). The transitions are:
- `ST_IDLE` to `ST_DOWN` on a deeper request.
- `ST_IDLE` to `ST_UP` on a shallower request or a wake.
- `ST_DOWN` to `ST_IDLE` when the target is reached.
- `ST_DOWN` to `ST_UP` on a wake.
- `ST_UP` to `ST_LOCK` when leaving sleep with the PLL off.
- `ST_LOCK` to `ST_UP` when the wait ends.
- `ST_UP` or `ST_LOCK` to `ST_IDLE` when the target is reached.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, the outputs are as follows: `mode_stat` is 00, `busy` is 0, and the bus, generator and PLL outputs are 1. Every unit enable is 1.
- R2: The mode code is 00 full-on, 01 doze, 10 nap, 11 sleep. A deeper request strobed at edge E0 raises `busy` at E1. The mode then advances one level per edge from E2 onward. `busy` falls on the edge that reaches the target.
- R3: In doze, all unit enables are 0, while the bus and generator enables are 1.
- R4: In nap, the bus enable is also 0 and the generator enable stays 1.
- R5: In sleep, the generator enable is 0. `pll_on` equals the value `pll_keep` had on the edge that entered sleep. Later changes of `pll_keep` are ignored until sleep is left.
- R6: In full-on, `unit_clk_en[i]` is the inverse of `unit_idle[i]`, one edge later. In any other mode, `unit_idle` has no effect and the unit enables stay 0.
- R7: A wake pulse seen at edge E0 in a low-power mode raises `busy` at E1. Then generator, bus and unit enables return on successive edges, and full-on is reached with `busy` low.
- R8: When sleep was entered with the PLL off, `pll_on` and the generator enable rise together on the first step out. The bus enable then rises `lock_delay`+1 edges later instead of 1.
- R9: A request strobed while a move is under way is held, and the latest one wins. It is acted on in the cycle after the move completes.
- R10: A wake and a request seen at the same edge: the wake is served first, up to full-on, and the request is applied afterwards.
- R11: A wake seen during a descent reverses it from the current level without going deeper. A wake seen while stable in full-on has no effect.
- R12: A request for the current mode starts no move, and `busy` stays 0.
- R13: At all times: bus on implies generator on; any unit on implies bus on and mode 00; the mode changes by at most one level per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_req_valid | input | 1 | One-cycle strobe of a mode request |
| mode_req | input | 2 | Requested mode code |
| pll_keep | input | 1 | 1 keeps the PLL powered in sleep |
| lock_delay | input | LOCK_W | Extra lock-wait cycles after PLL power-up |
| unit_idle | input | N_UNITS | Per-unit idle indication |
| wake_evt | input | 1 | External wake event |
| unit_clk_en | output | N_UNITS | Registered per-unit clock enables |
| bus_clk_en | output | 1 | Registered bus interface clock enable |
| gen_clk_en | output | 1 | Registered clock generator enable |
| pll_on | output | 1 | PLL keep-alive |
| mode_stat | output | 2 | Current mode code |
| busy | output | 1 | A mode move is under way |

## Verification
A software request and a wake event can land on the same edge, and the sequencer must pick one without losing the other. The bench strobes both together while the subsystem is in sleep. It then checks that the climb goes all the way to full-on rather than stopping at the requested level, and that the held request is applied only once full-on is reached. A second collision, a wake arriving in the middle of a descent, is provoked two edges after a sleep request. It is judged by the level never passing doze and by full-on being reached on the following edge.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        LV_FULL  = 2'b00,
        LV_DOZE  = 2'b01,
        LV_NAP   = 2'b10,
        LV_SLEEP = 2'b11
    } pwr_lvl_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DOWN,
        ST_UP,
        ST_LOCK
    } seq_st_e;
endpackage

// File: rtl/pmc_wake_det.sv
module pmc_wake_det (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_evt,
    input  logic armed,
    input  logic take,
    output logic pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (pend & ~take) | (wake_evt & armed);
    end
endmodule

// File: rtl/pmc_req_hold.sv
module pmc_req_hold
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_code,
    input  logic       take,
    output logic       pend,
    output pwr_lvl_e   pend_lvl
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            pend_lvl <= LV_FULL;
        end else begin
            pend <= req_valid | (pend & ~take);
            if (req_valid) pend_lvl <= pwr_lvl_e'(req_code);
        end
    end
endmodule

// File: rtl/pmc_unit_map.sv
module pmc_unit_map #(
    parameter int N_UNITS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_nxt,
    input  logic [N_UNITS-1:0] idle,
    output logic [N_UNITS-1:0] en
);
    for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) en[i] <= 1'b1;
            else        en[i] <= run_nxt & ~idle[i];
        end
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int N_UNITS = 4,
    parameter int LOCK_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_req_valid,
    input  logic [1:0]         mode_req,
    input  logic               pll_keep,
    input  logic [LOCK_W-1:0]  lock_delay,
    input  logic [N_UNITS-1:0] unit_idle,
    input  logic               wake_evt,
    output logic [N_UNITS-1:0] unit_clk_en,
    output logic               bus_clk_en,
    output logic               gen_clk_en,
    output logic               pll_on,
    output logic [1:0]         mode_stat,
    output logic               busy
);
    seq_st_e            st, nxt_st;
    pwr_lvl_e           lvl, nxt_lvl, tgt, nxt_tgt, eff_tgt, lvl_inc, lvl_dec;
    logic [LOCK_W-1:0]  cnt, nxt_cnt;
    logic               pll_off, nxt_off;
    logic               wake_pend, wake_take, wake_armed;
    logic               req_pend, req_take;
    pwr_lvl_e           req_lvl;

    assign wake_armed = (lvl != LV_FULL) || (st == ST_DOWN);
    assign lvl_inc    = pwr_lvl_e'(lvl + 2'd1);
    assign lvl_dec    = pwr_lvl_e'(lvl - 2'd1);

    pmc_wake_det u_wake (
        .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt),
        .armed(wake_armed), .take(wake_take), .pend(wake_pend)
    );

    pmc_req_hold u_hold (
        .clk(clk), .rst_n(rst_n), .req_valid(mode_req_valid), .req_code(mode_req),
        .take(req_take), .pend(req_pend), .pend_lvl(req_lvl)
    );

    pmc_unit_map #(.N_UNITS(N_UNITS)) u_map (
        .clk(clk), .rst_n(rst_n), .run_nxt(nxt_lvl == LV_FULL),
        .idle(unit_idle), .en(unit_clk_en)
    );

    always_comb begin
        nxt_st    = st;
        nxt_lvl   = lvl;
        nxt_tgt   = tgt;
        nxt_cnt   = cnt;
        nxt_off   = pll_off;
        wake_take = 1'b0;
        req_take  = 1'b0;
        eff_tgt   = tgt;
        if (wake_pend && (st == ST_UP || st == ST_LOCK)) begin
            eff_tgt   = LV_FULL;
            nxt_tgt   = LV_FULL;
            wake_take = 1'b1;
        end
        unique case (st)
            ST_IDLE: begin
                wake_take = wake_pend;
                if (wake_pend && lvl != LV_FULL) begin
                    nxt_tgt = LV_FULL;
                    nxt_st  = ST_UP;
                end else if (req_pend) begin
                    req_take = 1'b1;
                    if (req_lvl > lvl) begin
                        nxt_tgt = req_lvl;
                        nxt_st  = ST_DOWN;
                    end else if (req_lvl < lvl) begin
                        nxt_tgt = req_lvl;
                        nxt_st  = ST_UP;
                    end
                end
            end
            ST_DOWN: begin
                if (wake_pend) begin
                    wake_take = 1'b1;
                    nxt_tgt   = LV_FULL;
                    nxt_st    = (lvl == LV_FULL) ? ST_IDLE : ST_UP;
                end else begin
                    nxt_lvl = lvl_inc;
                    if (lvl_inc == LV_SLEEP) nxt_off = ~pll_keep;
                    if (lvl_inc == tgt)      nxt_st  = ST_IDLE;
                end
            end
            ST_UP: begin
                if (lvl <= eff_tgt) begin
                    nxt_st = ST_IDLE;
                end else if (lvl == LV_SLEEP) begin
                    nxt_lvl = LV_NAP;
                    nxt_off = 1'b0;
                    if (pll_off) begin
                        nxt_cnt = lock_delay;
                        nxt_st  = ST_LOCK;
                    end else if (eff_tgt == LV_NAP) begin
                        nxt_st  = ST_IDLE;
                    end
                end else begin
                    nxt_lvl = lvl_dec;
                    if (lvl_dec == eff_tgt) nxt_st = ST_IDLE;
                end
            end
            ST_LOCK: begin
                if (cnt != '0) begin
                    nxt_cnt = cnt - LOCK_W'(1);
                end else if (lvl <= eff_tgt) begin
                    nxt_st = ST_IDLE;
                end else begin
                    nxt_lvl = lvl_dec;
                    nxt_st  = (lvl_dec == eff_tgt) ? ST_IDLE : ST_UP;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            lvl     <= LV_FULL;
            tgt     <= LV_FULL;
            cnt     <= '0;
            pll_off <= 1'b0;
        end else begin
            st      <= nxt_st;
            lvl     <= nxt_lvl;
            tgt     <= nxt_tgt;
            cnt     <= nxt_cnt;
            pll_off <= nxt_off;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_stat  <= 2'b00;
            bus_clk_en <= 1'b1;
            gen_clk_en <= 1'b1;
            pll_on     <= 1'b1;
            busy       <= 1'b0;
        end else begin
            mode_stat  <= nxt_lvl;
            bus_clk_en <= (nxt_lvl == LV_FULL) || (nxt_lvl == LV_DOZE);
            gen_clk_en <= (nxt_lvl != LV_SLEEP);
            pll_on     <= !((nxt_lvl == LV_SLEEP) && nxt_off);
            busy       <= (nxt_st != ST_IDLE);
        end
    end
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
    parameter int N_UNITS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_UNITS-1:0] unit_clk_en,
    input logic               bus_clk_en,
    input logic               gen_clk_en,
    input logic               pll_on,
    input logic [1:0]         mode_stat,
    input logic               busy
);
    // R13
    bus_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clk_en |-> gen_clk_en);

    // R13
    unit_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|unit_clk_en) |-> (bus_clk_en && mode_stat == 2'b00));

    // R13
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stat != $past(mode_stat)) |->
            ((2'(mode_stat - $past(mode_stat)) == 2'd1) ||
             (2'($past(mode_stat) - mode_stat) == 2'd1)));

    // R5
    pll_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_on |-> (mode_stat == 2'b11 && !gen_clk_en));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(mode_stat));

    // R4
    nap_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stat == 2'b10) |-> (!bus_clk_en && gen_clk_en));
endmodule

bind pwr_mode_ctrl pmc_chk #(.N_UNITS(N_UNITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .unit_clk_en(unit_clk_en),
    .bus_clk_en(bus_clk_en), .gen_clk_en(gen_clk_en), .pll_on(pll_on),
    .mode_stat(mode_stat), .busy(busy)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NU = 4;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_req_valid = 1'b0;
    logic [1:0]    mode_req = 2'b00;
    logic          pll_keep = 1'b1;
    logic [LW-1:0] lock_delay = 8'd5;
    logic [NU-1:0] unit_idle = '0;
    logic          wake_evt = 1'b0;
    logic [NU-1:0] unit_clk_en;
    logic          bus_clk_en, gen_clk_en, pll_on, busy;
    logic [1:0]    mode_stat;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl #(.N_UNITS(NU), .LOCK_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_req_valid(mode_req_valid),
        .mode_req(mode_req), .pll_keep(pll_keep), .lock_delay(lock_delay),
        .unit_idle(unit_idle), .wake_evt(wake_evt), .unit_clk_en(unit_clk_en),
        .bus_clk_en(bus_clk_en), .gen_clk_en(gen_clk_en), .pll_on(pll_on),
        .mode_stat(mode_stat), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic req(input logic [1:0] m);
        mode_req_valid = 1'b1;
        mode_req       = m;
        tick();
        mode_req_valid = 1'b0;
    endtask

    task automatic wake();
        wake_evt = 1'b1;
        tick();
        wake_evt = 1'b0;
    endtask

    task automatic settle_full();
        wake();
        for (int i = 0; i < 40; i++) begin
            if (mode_stat == 2'b00 && !busy) break;
            tick();
        end
        chk("settle full-on", mode_stat, 0);
    endtask

    task automatic t_reset();
        tick();
        chk("R1 mode", mode_stat, 0);
        chk("R1 busy", busy, 0);
        chk("R1 bus/gen/pll", {bus_clk_en, gen_clk_en, pll_on}, 7);
        chk("R1 units", unit_clk_en, 15);
    endtask

    task automatic t_units();
        unit_idle = 4'b0101;
        tick();
        chk("R6 unit map", unit_clk_en, 4'b1010);
        unit_idle = 4'b0000;
        tick();
        chk("R6 unit map restore", unit_clk_en, 4'b1111);
    endtask

    task automatic t_enter_sleep(input logic keep);
        pll_keep = keep;
        req(2'b11);
        chk("R2 E0 not busy", busy, 0);
        tick();
        chk("R2 E1 busy", busy, 1);
        chk("R2 E1 mode", mode_stat, 0);
        tick();
        chk("R3 doze mode", mode_stat, 1);
        chk("R3 doze units", unit_clk_en, 0);
        chk("R3 doze bus/gen", {bus_clk_en, gen_clk_en}, 3);
        tick();
        chk("R4 nap mode", mode_stat, 2);
        chk("R4 nap bus/gen", {bus_clk_en, gen_clk_en}, 1);
        chk("R13 gen covers bus", int'(gen_clk_en >= bus_clk_en), 1);
        tick();
        chk("R5 sleep mode", mode_stat, 3);
        chk("R2 busy falls at target", busy, 0);
        chk("R5 gen off", gen_clk_en, 0);
        chk("R5 pll follows keep", pll_on, keep);
        unit_idle = 4'b0000;
        pll_keep  = ~keep;
        tick();
        chk("R6 units ignored in sleep", unit_clk_en, 0);
        chk("R5 keep change ignored", pll_on, keep);
        pll_keep = keep;
    endtask

    task automatic t_wake_keep();
        wake();
        tick();
        chk("R7 busy on wake", busy, 1);
        tick();
        chk("R7 gen first", {gen_clk_en, bus_clk_en}, 2);
        tick();
        chk("R7 bus second", {bus_clk_en, mode_stat}, 5);
        chk("R7 units still off", unit_clk_en, 0);
        tick();
        chk("R7 full-on", mode_stat, 0);
        chk("R7 units back", unit_clk_en, 15);
        chk("R7 busy low", busy, 0);
    endtask

    task automatic t_wake_lock();
        wake();
        tick();
        tick();
        chk("R8 pll and gen together", {pll_on, gen_clk_en}, 3);
        for (int i = 0; i < 5; i++) tick();
        chk("R8 bus held during lock", bus_clk_en, 0);
        tick();
        chk("R8 bus after lock", bus_clk_en, 1);
        tick();
        chk("R8 full-on", mode_stat, 0);
    endtask

    task automatic t_held_req();
        pll_keep = 1'b1;
        req(2'b11);
        tick();
        req(2'b10);
        req(2'b01);
        tick();
        chk("R9 reached sleep", mode_stat, 3);
        chk("R9 idle at sleep", busy, 0);
        tick();
        chk("R9 held request starts", busy, 1);
        tick();
        tick();
        chk("R9 latest request wins", mode_stat, 1);
        chk("R9 move done", busy, 0);
        tick();
        tick();
        chk("R9 stays doze", mode_stat, 1);
        settle_full();
    endtask

    task automatic t_wake_vs_req();
        t_enter_sleep(1'b1);
        wake_evt       = 1'b1;
        mode_req_valid = 1'b1;
        mode_req       = 2'b01;
        tick();
        wake_evt       = 1'b0;
        mode_req_valid = 1'b0;
        tick();
        tick();
        tick();
        tick();
        chk("R10 wake climbs to full", mode_stat, 0);
        chk("R10 climb ends", busy, 0);
        tick();
        chk("R10 request follows", busy, 1);
        tick();
        chk("R10 request applied", mode_stat, 1);
        settle_full();
    endtask

    task automatic t_wake_descent();
        req(2'b11);
        tick();
        wake();
        chk("R11 first step", mode_stat, 1);
        tick();
        chk("R11 reversed at doze", mode_stat, 1);
        chk("R11 still busy", busy, 1);
        tick();
        chk("R11 full-on", mode_stat, 0);
        chk("R11 busy low", busy, 0);
        tick();
        tick();
        chk("R11 no further descent", mode_stat, 0);
        wake();
        tick();
        chk("R11 wake at full ignored", {busy, mode_stat}, 0);
    endtask

    task automatic t_same_mode();
        req(2'b00);
        tick();
        chk("R12 no busy", busy, 0);
        tick();
        chk("R12 mode kept", mode_stat, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_units();
        t_enter_sleep(1'b1);
        t_wake_keep();
        t_enter_sleep(1'b0);
        t_wake_lock();
        t_held_req();
        t_wake_vs_req();
        t_wake_descent();
        t_same_mode();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule